// File: doc/BRIEF.md
# Line-Paced Audio Timer Bank

This block holds three programmable timers for an audio processor. A video timing generator advances them with a one-cycle tick per scanline and a flag that marks odd lines. Each timer has an enable and an 8-bit divide target. Each timer also has a 4-bit event counter that software reads. A read clears that counter.

Timer 2 is the fast timer. On every enabled tick, four units go into its accumulator. The target is then subtracted as many times as it fits, up to two times, and each subtraction is one event. Timers 0 and 1 are the slow timers. They add one unit, and only on odd lines. When a slow timer reaches its target, its accumulator restarts from zero and one event is counted. Any event raises a one-cycle wake pulse so the audio processor can leave its idle loop.

Top module: `audio_timer_bank`

## Requirements
- R1: When `line_tick_i` and `en_i[2]` are both 1, the fast timer (timer 2) adds 4 to its accumulator. It then takes the effective target away while the sum still reaches it, and adds 1 to its counter for each subtraction. After k enabled ticks from reset, counter 2 equals floor(4k/T) mod 16. The counter shows the new value from the clock edge that samples the tick.
- R2: The fast timer can count two events on a single tick. A fast target of 1 behaves as 2, so with a target of 1 or 2 counter 2 rises by exactly 2 on every enabled tick.
- R3: The slow timers (timers 0 and 1) change only on ticks where `line_odd_i` is 1. A tick with `line_odd_i` at 0 changes neither slow counter.
- R4: On a tick with `line_odd_i` at 1 and its enable set, a slow timer adds 1 to its accumulator. When the result reaches or passes the target, the accumulator goes back to 0 and the counter adds 1. After k such ticks the counter equals floor(k/T) mod 16.
- R5: A target field of 0 means 256, for all three timers.
- R6: Each counter is 4 bits wide and wraps from 15 to 0.
- R7: While a timer's enable is 0, its accumulator and counter keep their values. Counting resumes from the held accumulator when the enable returns.
- R8: A 1 on `rd_clr_i[i]` clears counter i at the next clock edge and leaves the accumulator unchanged. If the same edge also counts events for that timer, the counter then holds just that edge's events.
- R9: `wake_o` is 1 for exactly the cycle after an edge at which any counter counted an event. At all other times it is 0.
- R10: Reset (`rst_n` low) sets all accumulators and counters to 0 and `wake_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_tick_i | input | 1 | One-cycle pulse once per scanline |
| line_odd_i | input | 1 | 1 when the current line number is odd |
| en_i | input | 3 | Enable for each timer; bit i is timer i |
| rd_clr_i | input | 3 | Read strobe for each counter; clears counter i |
| tgt_i | input | 3*TGT_W | Targets; timer i uses bits [i*TGT_W +: TGT_W], and 0 means 256 |
| cnt_o | output | 3*CNT_W | Counters; timer i is at bits [i*CNT_W +: CNT_W] |
| wake_o | output | 1 | Pulse that reports an event to the audio processor |

## Verification
Every result is due one rising edge after the stimulus. The counters, the clear and `wake_o` all change at the edge that samples `line_tick_i` or `rd_clr_i`, and `wake_o` falls again at the edge after that. The bench changes its inputs on the falling edge and removes the tick at the next falling edge. It reads every counter and `wake_o` at that same falling edge, which lies exactly one rising edge after the stimulus. The expected values come from closed forms, floor(step·k/T) mod 16, taken relative to the count at the last clear. Here k counts the ticks that could advance each timer, so no timer state has to be copied into the bench.

// File: rtl/atb_pkg.sv
package atb_pkg;

   localparam int unsigned NUM_TIMERS = 3;
   localparam int unsigned FAST_IDX   = 2;

   typedef enum logic {TK_SLOW = 1'b0, TK_FAST = 1'b1} tkind_e;

   function automatic tkind_e timer_kind(input int unsigned idx);
      return (idx == FAST_IDX) ? TK_FAST : TK_SLOW;
   endfunction

endpackage

// File: rtl/atb_nibble_ctr.sv
module atb_nibble_ctr #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned INC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] q
);

   if (INC_W > CNT_W) begin : g_bad_inc
      $error("atb_nibble_ctr: INC_W must not exceed CNT_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (clr ? '0 : q) + CNT_W'(inc);
   end

endmodule

// File: rtl/atb_slow_acc.sv
module atb_slow_acc #(
   parameter int unsigned TGT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [TGT_W-1:0] tgt,
   output logic             hit
);

   localparam int unsigned AW = TGT_W + 1;

   logic [AW-1:0] acc_q;
   logic [AW-1:0] teff;
   logic [AW-1:0] nxt;

   always_comb begin
      teff = (tgt == '0) ? (AW'(1) << TGT_W) : AW'(tgt);
      nxt  = acc_q + AW'(1);
      hit  = adv && (nxt >= teff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (hit) acc_q <= '0;
      else if (adv) acc_q <= nxt;
   end

endmodule

// File: rtl/atb_fast_acc.sv
module atb_fast_acc #(
   parameter int unsigned TGT_W   = 8,
   parameter int unsigned STEP    = 4,
   parameter int unsigned MIN_TGT = 2,
   parameter int unsigned MAX_SUB = 2,
   parameter int unsigned SUB_W   = $clog2(MAX_SUB + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [TGT_W-1:0] tgt,
   output logic [SUB_W-1:0] subs
);

   localparam int unsigned AW = $clog2((1 << TGT_W) + STEP) + 1;

   if (MIN_TGT < 1) begin : g_bad_min
      $error("atb_fast_acc: MIN_TGT must be at least 1");
   end
   if (MIN_TGT - 1 + STEP >= (MAX_SUB + 1) * MIN_TGT) begin : g_bad_iter
      $error("atb_fast_acc: MAX_SUB too small for STEP and MIN_TGT");
   end

   logic [AW-1:0]    acc_q, acc_d;
   logic [AW-1:0]    teff, work;
   logic [SUB_W-1:0] n;

   always_comb begin
      if (tgt == '0)                  teff = AW'(1) << TGT_W;
      else if (AW'(tgt) < AW'(MIN_TGT)) teff = AW'(MIN_TGT);
      else                            teff = AW'(tgt);
      work = acc_q + AW'(STEP);
      n    = '0;
      for (int j = 0; j < int'(MAX_SUB); j++) begin
         if (work >= teff) begin
            work = work - teff;
            n    = n + SUB_W'(1);
         end
      end
      subs  = adv ? n : '0;
      acc_d = adv ? work : acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

endmodule

// File: rtl/audio_timer_bank.sv
module audio_timer_bank
   import atb_pkg::*;
#(
   parameter int unsigned TGT_W         = 8,
   parameter int unsigned CNT_W         = 4,
   parameter int unsigned FAST_STEP     = 4,
   parameter int unsigned FAST_MIN_TGT  = 2,
   parameter int unsigned FAST_MAX_SUB  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        line_tick_i,
   input  logic                        line_odd_i,
   input  logic [NUM_TIMERS-1:0]       en_i,
   input  logic [NUM_TIMERS-1:0]       rd_clr_i,
   input  logic [NUM_TIMERS*TGT_W-1:0] tgt_i,
   output logic [NUM_TIMERS*CNT_W-1:0] cnt_o,
   output logic                        wake_o
);

   localparam int unsigned SUB_W = $clog2(FAST_MAX_SUB + 1);

   if (TGT_W < 2) begin : g_bad_tgt
      $error("audio_timer_bank: TGT_W must be at least 2");
   end

   logic [NUM_TIMERS-1:0] any_inc;

   for (genvar g = 0; g < int'(NUM_TIMERS); g++) begin : g_tmr
      if (timer_kind(g) == TK_FAST) begin : g_fast
         logic [SUB_W-1:0] subs;
         atb_fast_acc #(
            .TGT_W(TGT_W), .STEP(FAST_STEP), .MIN_TGT(FAST_MIN_TGT),
            .MAX_SUB(FAST_MAX_SUB), .SUB_W(SUB_W)
         ) u_acc (
            .clk(clk), .rst_n(rst_n),
            .adv(line_tick_i & en_i[g]),
            .tgt(tgt_i[g*TGT_W +: TGT_W]),
            .subs(subs)
         );
         atb_nibble_ctr #(.CNT_W(CNT_W), .INC_W(SUB_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clr(rd_clr_i[g]),
            .inc(subs), .q(cnt_o[g*CNT_W +: CNT_W])
         );
         assign any_inc[g] = |subs;
      end else begin : g_slow
         logic hit;
         atb_slow_acc #(.TGT_W(TGT_W)) u_acc (
            .clk(clk), .rst_n(rst_n),
            .adv(line_tick_i & line_odd_i & en_i[g]),
            .tgt(tgt_i[g*TGT_W +: TGT_W]),
            .hit(hit)
         );
         atb_nibble_ctr #(.CNT_W(CNT_W), .INC_W(1)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clr(rd_clr_i[g]),
            .inc(hit), .q(cnt_o[g*CNT_W +: CNT_W])
         );
         assign any_inc[g] = hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_o <= 1'b0;
      else        wake_o <= |any_inc;
   end

endmodule

// File: rtl/atb_checker.sv
module atb_checker #(
   parameter int unsigned CNT_W        = 4,
   parameter int unsigned FAST_MAX_SUB = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           line_tick_i,
   input logic           line_odd_i,
   input logic [2:0]     en_i,
   input logic [2:0]     rd_clr_i,
   input logic [3*CNT_W-1:0] cnt_o,
   input logic           wake_o
);

   // R9: a wake pulse only follows a sampled tick
   a_r9_wake_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> $past(line_tick_i));

   // R3: no odd-line tick and no clear leaves slow counter 0 unchanged
   a_r3_even_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(line_tick_i && line_odd_i) && !rd_clr_i[0]) |=> $stable(cnt_o[0 +: CNT_W]));

   // R7: a disabled fast timer keeps its counter
   a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i[2] && !rd_clr_i[2]) |=> $stable(cnt_o[2*CNT_W +: CNT_W]));

   // R8: a clear with no event for timer 1 leaves it at zero
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i[1] && !(line_tick_i && line_odd_i && en_i[1])) |=> (cnt_o[CNT_W +: CNT_W] == '0));

   // R2: the fast counter never gains more than the iteration bound per edge
   a_r2_fast_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr_i[2] |=> (CNT_W'(cnt_o[2*CNT_W +: CNT_W] - $past(cnt_o[2*CNT_W +: CNT_W])) <= CNT_W'(FAST_MAX_SUB)));

endmodule

bind audio_timer_bank atb_checker #(.CNT_W(CNT_W), .FAST_MAX_SUB(FAST_MAX_SUB)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_tick_i(line_tick_i), .line_odd_i(line_odd_i),
   .en_i(en_i), .rd_clr_i(rd_clr_i), .cnt_o(cnt_o), .wake_o(wake_o)
);

// File: tb/sim_audio_timer_bank.sv
module sim_audio_timer_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_tick_i = 1'b0;
   logic        line_odd_i = 1'b0;
   logic [2:0]  en_i = '0;
   logic [2:0]  rd_clr_i = '0;
   logic [23:0] tgt_i = '0;
   logic [11:0] cnt_o;
   logic        wake_o;

   int checks = 0;
   int errors = 0;
   int tg[3];
   int kk[3];
   int base[3];
   bit done = 1'b0;

   always #4 clk = ~clk;

   audio_timer_bank u0 (
      .clk(clk), .rst_n(rst_n), .line_tick_i(line_tick_i), .line_odd_i(line_odd_i),
      .en_i(en_i), .rd_clr_i(rd_clr_i), .tgt_i(tgt_i), .cnt_o(cnt_o), .wake_o(wake_o)
   );

   function automatic int flr(int idx, int k);
      int step = (idx == 2) ? 4 : 1;
      int te = (tg[idx] == 0) ? 256 : tg[idx];
      if (idx == 2 && te < 2) te = 2;
      return (k * step) / te;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic start_case(int a, int b, int c);
      @(negedge clk);
      rst_n = 1'b0;
      line_tick_i = 1'b0;
      rd_clr_i = '0;
      en_i = 3'b111;
      tg[0] = a; tg[1] = b; tg[2] = c;
      tgt_i = {8'(c), 8'(b), 8'(a)};
      for (int i = 0; i < 3; i++) begin kk[i] = 0; base[i] = 0; end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset counters", int'(cnt_o), 0);
      chk("R10 reset wake", int'(wake_o), 0);
   endtask

   task automatic step(bit tk, bit odd, logic [2:0] clr, string tag);
      int fo[3];
      int fn[3];
      bit wexp = 1'b0;
      for (int i = 0; i < 3; i++) begin
         fo[i] = flr(i, kk[i]);
         if (tk && en_i[i] && (i == 2 || odd)) kk[i]++;
         fn[i] = flr(i, kk[i]);
         if (fn[i] != fo[i]) wexp = 1'b1;
         if (clr[i]) base[i] = fo[i];
      end
      line_tick_i = tk;
      line_odd_i = odd;
      rd_clr_i = clr;
      @(negedge clk);
      line_tick_i = 1'b0;
      rd_clr_i = '0;
      for (int i = 0; i < 3; i++)
         chk($sformatf("%s cnt%0d", tag, i), int'(cnt_o[i*4 +: 4]), (fn[i] - base[i]) & 15);
      chk($sformatf("%s R9 wake", tag), int'(wake_o), int'(wexp));
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1 R4: several targets, alternating line parity
      for (int t = 1; t <= 7; t++) begin
         start_case(t, t + 2, t + 1);
         for (int n = 0; n < 60; n++) step(1'b1, n[0], 3'b000, "R1 R4");
      end
      // R2: two events per tick, fast target 1 treated as 2
      start_case(1, 2, 2);
      for (int n = 0; n < 20; n++) step(1'b1, 1'b1, 3'b000, "R2");
      start_case(2, 7, 1);
      for (int n = 0; n < 20; n++) step(1'b1, n[0], 3'b000, "R2");
      start_case(4, 4, 3);
      for (int n = 0; n < 30; n++) step(1'b1, 1'b0, 3'b000, "R2");
      // R3: even lines only leave the slow timers still
      start_case(1, 1, 4);
      for (int n = 0; n < 12; n++) step(1'b1, 1'b0, 3'b000, "R3");
      for (int n = 0; n < 12; n++) step(1'b1, n[0], 3'b000, "R3");
      // R5: target 0 means 256
      start_case(0, 0, 0);
      for (int n = 0; n < 520; n++) step(1'b1, n[0], 3'b000, "R5");
      start_case(0, 255, 0);
      for (int n = 0; n < 520; n++) step(1'b1, 1'b1, 3'b000, "R5");
      // R6: wrap modulo 16
      start_case(1, 1, 2);
      for (int n = 0; n < 44; n++) step(1'b1, 1'b1, 3'b000, "R6");
      // R7: disabled timers hold their accumulators
      start_case(2, 3, 5);
      for (int n = 0; n < 13; n++) step(1'b1, n[0], 3'b000, "R7");
      en_i = 3'b010;
      for (int n = 0; n < 20; n++) step(1'b1, n[0], 3'b000, "R7");
      en_i = 3'b000;
      for (int n = 0; n < 10; n++) step(1'b1, 1'b1, 3'b000, "R7");
      en_i = 3'b111;
      for (int n = 0; n < 21; n++) step(1'b1, n[0], 3'b000, "R7");
      // R8: clears alone and coinciding with events
      start_case(1, 3, 2);
      for (int n = 0; n < 7; n++) step(1'b1, 1'b1, 3'b000, "R8");
      step(1'b0, 1'b0, 3'b111, "R8 idle clear");
      step(1'b0, 1'b0, 3'b000, "R8 idle");
      for (int n = 0; n < 5; n++) step(1'b1, 1'b1, 3'b000, "R8");
      step(1'b1, 1'b1, 3'b111, "R8 clear with tick");
      for (int n = 0; n < 4; n++) step(1'b1, n[0], 3'b000, "R8");
      step(1'b1, 1'b0, 3'b011, "R8 clear even tick");
      for (int n = 0; n < 6; n++) step(1'b1, 1'b1, 3'b100, "R8 repeated clear");
      step(1'b0, 1'b1, 3'b000, "R9 no tick");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule